// File: doc/BRIEF.md
# Saturating Instruction-Cache Statistics Counters

This block keeps three access-class counters for an instruction cache: reads that hit, reads that miss, and reads that bypass the cache as uncached. The cache core reports one access per cycle. It gives a valid flag, a write flag and a two-bit class code. The block turns each qualifying read into an increment of exactly one counter. A level-sensitive enable gates all counting. A single clear pulse resets all three counters together.

None of the counters wraps. When a counter reaches all ones it holds there. It also raises a one-cycle saturation event on its own bit of an event vector, which the interrupt logic can collect. The counter values are registered outputs intended for plain register readback. Address decoding and bus handling sit outside this block.

Top module: `stat_sat_counters`

## Requirements
- R1: An access with `acc_vld`=1, `acc_wr`=0 and `acc_kind`=0 (hit) while `stat_en`=1 raises `hit_count` by one on the next clock edge. The other counters stay unchanged.
- R2: The same read with `acc_kind`=1 (miss) raises only `miss_count` by one.
- R3: The same read with `acc_kind`=2 (uncached) raises only `unc_count` by one. Code 3 is reserved and changes no counter.
- R4: While `stat_en`=0 and `stat_clr`=0, all three counters hold their values whatever the access inputs do.
- R5: `stat_clr`=1 sets all three counters to zero on the next edge, whether `stat_en` is 0 or 1.
- R6: A counter at all ones (2^CNT_W-1) stays there on further increments and never wraps to zero.
- R7: `sat_evt` bit 0 (hit), bit 1 (miss) or bit 2 (uncached) is 1 for exactly the one cycle in which that counter first shows all ones. It stays 0 while the counter remains saturated.
- R8: An access with `acc_wr`=1 changes no counter, whatever its class code.
- R9: A clear in the same cycle as a qualifying read leaves every counter at zero, and `sat_evt` stays 0.
- R10: After reset all counters and `sat_evt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_en | input | 1 | Counting enable level |
| stat_clr | input | 1 | Clear-all pulse |
| acc_vld | input | 1 | Access reported this cycle |
| acc_wr | input | 1 | Reported access is a write |
| acc_kind | input | 2 | 0 hit, 1 miss, 2 uncached, 3 reserved |
| hit_count | output | CNT_W | Cached-read hit count |
| miss_count | output | CNT_W | Cached-read miss count |
| unc_count | output | CNT_W | Uncached-read count |
| sat_evt | output | 3 | One-cycle saturation events: bit 0 hit, 1 miss, 2 uncached |

## Verification
Random traffic mixes all class codes, write and read accesses, enable toggling and occasional clears. This shows whether each read lands in the right counter and whether writes, reserved codes and disabled cycles are dropped. Long directed bursts of one class drive each counter into saturation in turn, with a narrow counter width. These separate a clean stop at all ones and a single event pulse from wrapping or repeated pulses. A clear placed in the same cycle as an increment, both with and without enable, tells clear priority apart from a lost or late clear.

// File: rtl/stat_cnt_pkg.sv
package stat_cnt_pkg;

  localparam int NUM_CNT = 3;

  typedef enum logic [1:0] {
    KIND_HIT  = 2'd0,
    KIND_MISS = 2'd1,
    KIND_UNC  = 2'd2,
    KIND_RSVD = 2'd3
  } acc_kind_e;

  localparam int IDX_HIT  = 0;
  localparam int IDX_MISS = 1;
  localparam int IDX_UNC  = 2;

endpackage

// File: rtl/stat_evt_decode.sv
module stat_evt_decode
  import stat_cnt_pkg::*;
#(
  parameter int NCNT = NUM_CNT
) (
  input  logic            acc_vld,
  input  logic            acc_wr,
  input  logic [1:0]      acc_kind,
  output logic [NCNT-1:0] inc
);

  logic rd_ok;
  assign rd_ok = acc_vld && !acc_wr;

  // one counter per class code; code value equals counter index
  for (genvar g = 0; g < NCNT; g++) begin : g_dec
    assign inc[g] = rd_ok && (acc_kind == 2'(g));
  end

endmodule

// File: rtl/stat_sat_counter.sv
module stat_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             sat_pulse
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

  logic at_max;
  logic bump;
  assign at_max = (count == CNT_MAX);
  assign bump   = en && inc && !at_max;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count     <= '0;
      sat_pulse <= 1'b0;
    end else begin
      sat_pulse <= bump && (count == CNT_LAST);
      if (bump) count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/stat_sat_counters.sv
module stat_sat_counters
  import stat_cnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_en,
  input  logic             stat_clr,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic [1:0]       acc_kind,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count,
  output logic [CNT_W-1:0] unc_count,
  output logic [2:0]       sat_evt
);

  logic [NUM_CNT-1:0] inc_vec;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];
  logic [NUM_CNT-1:0] sat_vec;

  stat_evt_decode #(.NCNT(NUM_CNT)) u_dec (
    .acc_vld (acc_vld),
    .acc_wr  (acc_wr),
    .acc_kind(acc_kind),
    .inc     (inc_vec)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    stat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .en       (stat_en),
      .clr      (stat_clr),
      .inc      (inc_vec[g]),
      .count    (cnt_arr[g]),
      .sat_pulse(sat_vec[g])
    );
  end

  assign hit_count  = cnt_arr[IDX_HIT];
  assign miss_count = cnt_arr[IDX_MISS];
  assign unc_count  = cnt_arr[IDX_UNC];
  assign sat_evt    = sat_vec;

endmodule

// File: rtl/stat_sat_counters_chk.sv
module stat_sat_counters_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             stat_en,
  input logic             stat_clr,
  input logic             acc_vld,
  input logic             acc_wr,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic [CNT_W-1:0] unc_count,
  input logic [2:0]       sat_evt
);

  localparam logic [CNT_W-1:0] MAXV = '1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    stat_clr |=> (hit_count == '0 && miss_count == '0 && unc_count == '0 && sat_evt == 3'b0)); // R5

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!stat_en && !stat_clr) |=> ($stable(hit_count) && $stable(miss_count) && $stable(unc_count))); // R4

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && acc_wr && !stat_clr) |=> ($stable(hit_count) && $stable(miss_count) && $stable(unc_count))); // R8

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!stat_clr && hit_count == MAXV) |=> (hit_count == MAXV)); // R6

  AST_SAT_EDGE_HIT: assert property (@(posedge clk) disable iff (rst)
    sat_evt[0] |-> (hit_count == MAXV && $past(hit_count) != MAXV)); // R7

  AST_SAT_EDGE_MISS: assert property (@(posedge clk) disable iff (rst)
    sat_evt[1] |-> (miss_count == MAXV && $past(miss_count) != MAXV)); // R7

  AST_SAT_EDGE_UNC: assert property (@(posedge clk) disable iff (rst)
    sat_evt[2] |-> (unc_count == MAXV && $past(unc_count) != MAXV)); // R7

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
    !stat_clr |=> ($countones({hit_count != $past(hit_count), miss_count != $past(miss_count),
                              unc_count != $past(unc_count)}) <= 1)); // R1

endmodule

bind stat_sat_counters stat_sat_counters_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stat_en   (stat_en),
  .stat_clr  (stat_clr),
  .acc_vld   (acc_vld),
  .acc_wr    (acc_wr),
  .hit_count (hit_count),
  .miss_count(miss_count),
  .unc_count (unc_count),
  .sat_evt   (sat_evt)
);

// File: tb/stat_sat_counters_test.sv
`timescale 1ns/1ps
module stat_sat_counters_test;

  localparam int W = 10;
  localparam logic [W-1:0] MAXV = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stat_en = 1'b0;
  logic         stat_clr = 1'b0;
  logic         acc_vld = 1'b0;
  logic         acc_wr = 1'b0;
  logic [1:0]   acc_kind = 2'd0;
  logic [W-1:0] hit_count, miss_count, unc_count;
  logic [2:0]   sat_evt;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] m_cnt [3];
  logic [2:0]   m_sat;

  always #10 clk = ~clk;

  stat_sat_counters #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .stat_en(stat_en), .stat_clr(stat_clr),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_kind(acc_kind),
    .hit_count(hit_count), .miss_count(miss_count), .unc_count(unc_count),
    .sat_evt(sat_evt)
  );

  task automatic compare(input string tag);
    n_vec++;
    if (hit_count !== m_cnt[0] || miss_count !== m_cnt[1] ||
        unc_count !== m_cnt[2] || sat_evt !== m_sat) begin
      n_bad++;
      $display("FAIL %s: got hit=%0d miss=%0d unc=%0d sat=%b, expected hit=%0d miss=%0d unc=%0d sat=%b",
               tag, hit_count, miss_count, unc_count, sat_evt,
               m_cnt[0], m_cnt[1], m_cnt[2], m_sat);
    end
  endtask

  // drive one cycle, advance the model, compare after the edge
  task automatic step(input bit v, input bit w, input logic [1:0] k,
                      input bit e, input bit c, input string tag);
    acc_vld = v; acc_wr = w; acc_kind = k; stat_en = e; stat_clr = c;
    @(posedge clk);
    #1;
    for (int i = 0; i < 3; i++) begin
      m_sat[i] = 1'b0;
      if (c) m_cnt[i] = '0;
      else if (e && v && !w && k == 2'(i) && m_cnt[i] != MAXV) begin
        m_cnt[i] = m_cnt[i] + 1'b1;
        if (m_cnt[i] == MAXV) m_sat[i] = 1'b1;
      end
    end
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int unused;
    unused = $urandom(32'd1234);
    for (int i = 0; i < 3; i++) m_cnt[i] = '0;
    m_sat = '0;
    repeat (3) @(posedge clk);
    #1;
    compare("R10 reset");
    rst = 1'b0;
    #1;

    // R1 R2 R3 directed singles, R3 reserved code
    step(1, 0, 2'd0, 1, 0, "R1 hit");
    step(1, 0, 2'd1, 1, 0, "R2 miss");
    step(1, 0, 2'd2, 1, 0, "R3 uncached");
    step(1, 0, 2'd3, 1, 0, "R3 reserved code");
    // R8 writes of each class
    for (int k = 0; k < 4; k++) step(1, 1, 2'(k), 1, 0, "R8 write ignored");
    // R4 disabled reads
    for (int k = 0; k < 4; k++) step(1, 0, 2'(k), 0, 0, "R4 disabled hold");
    // R9 clear with increment, R5 clear while disabled
    step(1, 0, 2'd0, 1, 0, "R1 hit");
    step(1, 0, 2'd0, 1, 1, "R9 clear with increment");
    step(1, 0, 2'd1, 1, 0, "R2 miss");
    step(0, 0, 2'd0, 0, 1, "R5 clear while disabled");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[0] | r[1], r[2] & r[3], 2'($urandom), (r[4] | r[5]),
           ($urandom % 200) == 0, "R1/R2/R3/R4/R8 random");
    end

    // R6 R7 saturate each counter in turn
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 2'd0, 1, 1, "R5 clear before burst");
      for (int n = 0; n < 1030; n++) step(1, 0, 2'(k), 1, 0, "R6/R7 saturation burst");
    end
    // R9 clear at the saturating step: no pulse
    step(0, 0, 2'd0, 1, 1, "R5 clear");
    for (int n = 0; n < 1022; n++) step(1, 0, 2'd0, 1, 0, "R1 hit fill");
    step(1, 0, 2'd0, 1, 1, "R9 clear at saturating step");
    step(1, 0, 2'd0, 1, 0, "R1 hit after clear");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule